// File: doc/BRIEF.md
# External Video Timing Tracker

This block sits on a pixel clock in front of a test-pattern generator. It receives the display-enable (DE), horizontal sync (HS) and vertical sync (VS) controls of an incoming video stream. It forwards them bit for bit, two pixel clocks later, so that pixel data made downstream in the following cycle can line up with the delayed controls.

While forwarding, it measures the active picture from the controls themselves. The width is the number of DE-high clocks in a line. The height is the number of DE-high lines in a frame. The pattern generator uses these to scale its brightness gradients. The tracker also gives the pixel and line index of every delayed active pixel.

Frames are delimited in one of two ways:
- by the rising edge of VS;
- for streams without VS, by the first active pixel after a DE-low run longer than a programmable threshold.

A measurement is published only once two complete frames in a row agree. This keeps partial frames after reset, or a format change, from reaching the gradients.

The stream has no back-pressure. One pixel arrives per clock, DE acts as the valid qualifier, and there is no ready signal. The consumer must take the delayed controls and positions on every clock.

Top module: `vid_timing_tracker`

## Requirements
- R1: `de_out`, `hs_out` and `vs_out` equal `de_in`, `hs_in` and `vs_in` from exactly two clocks earlier. While reset is active they are 0.
- R2: The published width is the number of consecutive clocks with DE high in one line of the frame.
- R3: The published height is the number of DE-high runs (lines) between two successive frame starts.
- R4: With `use_vs` = 1, a frame starts at the clock where VS goes from 0 to 1. DE gaps of any length do not start a frame.
- R5: With `use_vs` = 0, a frame starts at the first DE-high clock that follows a DE-low run of strictly more than `gap_limit` clocks. A run of exactly `gap_limit` clocks is horizontal blanking, and VS is ignored.
- R6: `act_width`, `act_height` and `dims_valid` change only at a frame start. `dims_valid` rises only when the frame just ended measures the same non-zero width and height as the frame before it. It therefore stays 0 after the first frame following reset.
- R7: A frame that measures differently from its predecessor clears `dims_valid` and leaves `act_width` and `act_height` at their old values until two new frames agree.
- R8: While `de_out` is 1, `pos_x` is the 0-based pixel index in the current line and `pos_y` is the 0-based line index since the last frame start. While `de_out` is 0, `pos_x` is 0.
- R9: Active-low `rst_n` clears `dims_valid`, `act_width`, `act_height`, `pos_x` and `pos_y`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| use_vs | input | 1 | 1: frame start from VS rising edge; 0: from long DE-low gap |
| gap_limit | input | GAP_W | DE-low run length that must be exceeded to count as vertical blank |
| de_in | input | 1 | Incoming display enable |
| hs_in | input | 1 | Incoming horizontal sync |
| vs_in | input | 1 | Incoming vertical sync |
| de_out | output | 1 | `de_in` delayed two clocks |
| hs_out | output | 1 | `hs_in` delayed two clocks |
| vs_out | output | 1 | `vs_in` delayed two clocks |
| pos_x | output | DIM_W | Pixel index of the delayed active pixel |
| pos_y | output | DIM_W | Line index of the delayed active pixel |
| act_width | output | DIM_W | Confirmed active width |
| act_height | output | DIM_W | Confirmed active height |
| dims_valid | output | 1 | Width and height confirmed by two matching frames |

## Verification
The assertions check the following on every clock:
- the exact two-clock pass-through of the controls;
- the idle value of `pos_x` and its unit step along a line;
- the reset values;
- that the published dimensions never move without `dims_valid` being set.

Other behaviour depends on whole frames, so only the bench scenarios show it:
- the gap threshold boundary (a run of exactly `gap_limit` clocks staying horizontal blank);
- the VS-edge versus DE-gap framing;
- the requirement for two matching frames before publication;
- the loss of validity and later recovery when the format changes mid-stream.

The bench sweeps several small widths and heights in both framing modes. It compares every delayed control and position against its own record of what it drove.

// File: rtl/vtt_pkg.sv
package vtt_pkg;
  typedef struct packed {
    logic de;
    logic hs;
    logic vs;
  } ctrl_t;
endpackage

// File: rtl/vtt_delay_line.sv
// Fixed-latency register chain for the video controls.
module vtt_delay_line #(
  parameter int DEPTH = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  vtt_pkg::ctrl_t din,
  output vtt_pkg::ctrl_t dout
);
  vtt_pkg::ctrl_t stg [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg[0] <= '0;
        else        stg[0] <= din;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg[i] <= '0;
        else        stg[i] <= stg[i-1];
      end
    end
  end

  assign dout = stg[DEPTH-1];
endmodule

// File: rtl/vtt_frame_detect.sv
// Frame start from VS edge or from a long DE-low gap.
module vtt_frame_detect #(
  parameter int GAP_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             use_vs,
  input  logic [GAP_W-1:0] gap_limit,
  input  logic             de,
  input  logic             vs,
  output logic             frame_start,
  output logic             de_fall
);
  localparam logic [GAP_W-1:0] GAP_MAX = '1;

  logic             de_prev, vs_prev;
  logic [GAP_W-1:0] gap_cnt;
  logic             vs_edge, gap_edge;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      de_prev <= 1'b0;
      vs_prev <= 1'b0;
      gap_cnt <= '0;
    end else begin
      de_prev <= de;
      vs_prev <= vs;
      if (de)                     gap_cnt <= '0;
      else if (gap_cnt != GAP_MAX) gap_cnt <= gap_cnt + 1'b1;
    end
  end

  // gap_cnt holds the length of the DE-low run that just ended
  always_comb begin
    vs_edge     = vs & ~vs_prev;
    gap_edge    = de & ~de_prev & (gap_cnt > gap_limit);
    frame_start = use_vs ? vs_edge : gap_edge;
    de_fall     = de_prev & ~de;
  end
endmodule

// File: rtl/vtt_dim_measure.sv
// Width/height measurement with two-frame agreement.
module vtt_dim_measure #(
  parameter int DIM_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             de,
  input  logic             de_fall,
  input  logic             frame_start,
  output logic [DIM_W-1:0] act_width,
  output logic [DIM_W-1:0] act_height,
  output logic             dims_valid
);
  logic [DIM_W-1:0] run_cnt, last_w, line_cnt;
  logic [DIM_W-1:0] cand_w, cand_h;
  logic             have_cand;
  logic [DIM_W-1:0] eff_w, eff_h;
  logic             agree;

  // a line that ends on the frame-start clock still belongs to the old frame
  always_comb begin
    eff_w = de_fall ? run_cnt : last_w;
    eff_h = line_cnt + DIM_W'(de_fall);
    agree = have_cand && (eff_w == cand_w) && (eff_h == cand_h) &&
            (eff_w != '0) && (eff_h != '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_cnt <= '0;
      last_w  <= '0;
      line_cnt <= '0;
    end else begin
      run_cnt <= de ? run_cnt + 1'b1 : '0;
      if (de_fall) last_w <= run_cnt;
      if (frame_start)  line_cnt <= '0;
      else if (de_fall) line_cnt <= line_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cand_w     <= '0;
      cand_h     <= '0;
      have_cand  <= 1'b0;
      act_width  <= '0;
      act_height <= '0;
      dims_valid <= 1'b0;
    end else if (frame_start) begin
      cand_w    <= eff_w;
      cand_h    <= eff_h;
      have_cand <= 1'b1;
      if (agree) begin
        act_width  <= eff_w;
        act_height <= eff_h;
        dims_valid <= 1'b1;
      end else begin
        dims_valid <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/vtt_position.sv
// Pixel/line position aligned with the two-clock-delayed DE.
module vtt_position #(
  parameter int DIM_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             de,
  input  logic             frame_start,
  output logic [DIM_W-1:0] pos_x,
  output logic [DIM_W-1:0] pos_y
);
  logic de_d1, de_d2, fs_d1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      de_d1 <= 1'b0;
      de_d2 <= 1'b0;
      fs_d1 <= 1'b0;
      pos_x <= '0;
      pos_y <= '0;
    end else begin
      de_d1 <= de;
      de_d2 <= de_d1;
      fs_d1 <= frame_start;
      if (de_d1) pos_x <= de_d2 ? pos_x + 1'b1 : '0;
      else       pos_x <= '0;
      if (fs_d1)               pos_y <= '0;
      else if (de_d2 && !de_d1) pos_y <= pos_y + 1'b1;
    end
  end
endmodule

// File: rtl/vid_timing_tracker.sv
module vid_timing_tracker #(
  parameter int DIM_W = 12,
  parameter int GAP_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             use_vs,
  input  logic [GAP_W-1:0] gap_limit,
  input  logic             de_in,
  input  logic             hs_in,
  input  logic             vs_in,
  output logic             de_out,
  output logic             hs_out,
  output logic             vs_out,
  output logic [DIM_W-1:0] pos_x,
  output logic [DIM_W-1:0] pos_y,
  output logic [DIM_W-1:0] act_width,
  output logic [DIM_W-1:0] act_height,
  output logic             dims_valid
);
  localparam int LAT = 2;

  vtt_pkg::ctrl_t ctl_in, ctl_out;
  logic           frame_start, de_fall;

  assign ctl_in = '{de: de_in, hs: hs_in, vs: vs_in};

  vtt_delay_line #(.DEPTH(LAT)) u_dly (
    .clk(clk), .rst_n(rst_n), .din(ctl_in), .dout(ctl_out)
  );

  assign de_out = ctl_out.de;
  assign hs_out = ctl_out.hs;
  assign vs_out = ctl_out.vs;

  vtt_frame_detect #(.GAP_W(GAP_W)) u_fdet (
    .clk(clk), .rst_n(rst_n), .use_vs(use_vs), .gap_limit(gap_limit),
    .de(de_in), .vs(vs_in), .frame_start(frame_start), .de_fall(de_fall)
  );

  vtt_dim_measure #(.DIM_W(DIM_W)) u_meas (
    .clk(clk), .rst_n(rst_n), .de(de_in), .de_fall(de_fall),
    .frame_start(frame_start), .act_width(act_width),
    .act_height(act_height), .dims_valid(dims_valid)
  );

  vtt_position #(.DIM_W(DIM_W)) u_pos (
    .clk(clk), .rst_n(rst_n), .de(de_in), .frame_start(frame_start),
    .pos_x(pos_x), .pos_y(pos_y)
  );
endmodule

// File: rtl/vtt_checker.sv
module vtt_checker #(
  parameter int DIM_W = 12
) (
  input logic             clk,
  input logic             rst_n,
  input logic             de_in,
  input logic             hs_in,
  input logic             vs_in,
  input logic             de_out,
  input logic             hs_out,
  input logic             vs_out,
  input logic [DIM_W-1:0] pos_x,
  input logic [DIM_W-1:0] pos_y,
  input logic [DIM_W-1:0] act_width,
  input logic [DIM_W-1:0] act_height,
  input logic             dims_valid
);
  logic [1:0] cyc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         cyc <= '0;
    else if (cyc != 2'd3) cyc <= cyc + 1'b1;
  end

  // R1
  pass_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc >= 2'd2) |-> ({de_out, hs_out, vs_out} == $past({de_in, hs_in, vs_in}, 2)));

  // R8
  idle_x_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !de_out |-> (pos_x == '0));

  // R8
  x_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc >= 2'd1 && de_out && $past(de_out)) |-> (pos_x == DIM_W'($past(pos_x) + 1'b1)));

  // R6
  dims_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc >= 2'd1 && (act_width != $past(act_width) || act_height != $past(act_height)))
      |-> dims_valid);

  // R9
  reset_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc == 2'd0) |-> (!dims_valid && act_width == '0 && act_height == '0 &&
                       pos_x == '0 && pos_y == '0));
endmodule

bind vid_timing_tracker vtt_checker #(.DIM_W(DIM_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .de_in(de_in), .hs_in(hs_in), .vs_in(vs_in),
  .de_out(de_out), .hs_out(hs_out), .vs_out(vs_out), .pos_x(pos_x),
  .pos_y(pos_y), .act_width(act_width), .act_height(act_height),
  .dims_valid(dims_valid)
);

// File: tb/vid_timing_tracker_test.sv
module vid_timing_tracker_test;
  localparam int DIM_W = 12;
  localparam int GAP_W = 12;
  localparam int LIMIT = 6;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             use_vs = 1'b0;
  logic [GAP_W-1:0] gap_limit = GAP_W'(LIMIT);
  logic             de_in = 1'b0, hs_in = 1'b0, vs_in = 1'b0;
  logic             de_out, hs_out, vs_out, dims_valid;
  logic [DIM_W-1:0] pos_x, pos_y, act_width, act_height;

  int  total = 0, bad = 0;
  bit  done = 0;
  bit  seen_low = 0;
  int  h1c = 0, h2c = 0, h1x = 0, h1y = 0, h2x = 0, h2y = 0;

  always #10 clk = ~clk;

  vid_timing_tracker #(.DIM_W(DIM_W), .GAP_W(GAP_W)) uut (
    .clk(clk), .rst_n(rst_n), .use_vs(use_vs), .gap_limit(gap_limit),
    .de_in(de_in), .hs_in(hs_in), .vs_in(vs_in),
    .de_out(de_out), .hs_out(hs_out), .vs_out(vs_out),
    .pos_x(pos_x), .pos_y(pos_y), .act_width(act_width),
    .act_height(act_height), .dims_valid(dims_valid)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // one clock: check delayed outputs against history, then drive new inputs
  task automatic tick(input int de, input int hs, input int vs, input int x, input int y);
    int act;
    @(negedge clk);
    act = {29'd0, de_out, hs_out, vs_out};
    chk(act == h2c, "R1 pass-through", act, h2c);
    if (de_out) begin
      chk(int'(pos_x) == h2x, "R8 pos_x", int'(pos_x), h2x);
      chk(int'(pos_y) == h2y, "R8 pos_y", int'(pos_y), h2y);
    end else begin
      chk(pos_x == '0, "R8 idle pos_x", int'(pos_x), 0);
    end
    if (!dims_valid) seen_low = 1;
    h2c = h1c; h2x = h1x; h2y = h1y;
    h1c = (de << 2) | (hs << 1) | vs; h1x = x; h1y = y;
    de_in = de[0]; hs_in = hs[0]; vs_in = vs[0];
  endtask

  task automatic do_reset(input bit mode_vs);
    rst_n = 1'b0;
    use_vs = mode_vs;
    h1c = 0; h2c = 0;
    repeat (3) tick(0, 0, 0, 0, 0);
    rst_n = 1'b1;
    // R9
    chk(!dims_valid, "R9 dims_valid", int'(dims_valid), 0);
    chk(act_width == '0 && act_height == '0, "R9 dims",
        int'(act_width) + int'(act_height), 0);
    chk(pos_x == '0 && pos_y == '0, "R9 pos", int'(pos_x) + int'(pos_y), 0);
  endtask

  task automatic blank(input int n, input bit mode_vs);
    for (int i = 0; i < n; i++)
      tick(0, (i == 0) ? 1 : 0, (mode_vs && i < 2) ? 1 : 0, 0, 0);
  endtask

  // R5: in gap mode a stray VS pulse mid-line must be ignored
  task automatic frame(input int w, input int h, input bit mode_vs);
    int hbl, vbl;
    hbl = mode_vs ? 3 : LIMIT;
    vbl = mode_vs ? 4 : LIMIT + 1;
    for (int l = 0; l < h; l++) begin
      for (int p = 0; p < w; p++)
        tick(1, 0, (!mode_vs && l == 0 && p == w / 2) ? 1 : 0, p, l);
      if (l < h - 1) for (int i = 0; i < hbl; i++) tick(0, (i == 0) ? 1 : 0, 0, 0, 0);
      else blank(vbl, mode_vs);
    end
  endtask

  task automatic run_cfg(input bit mode_vs, input int w, input int h);
    string rq;
    rq = mode_vs ? "R4" : "R5";
    do_reset(mode_vs);
    blank(mode_vs ? 4 : LIMIT + 1, mode_vs);
    frame(w, h, mode_vs);
    // R6: one frame is never enough
    chk(!dims_valid, "R6 single frame", int'(dims_valid), 0);
    frame(w, h, mode_vs);
    frame(w, h, mode_vs);
    chk(dims_valid, {"R6 valid ", rq}, int'(dims_valid), 1);
    chk(int'(act_width) == w, {"R2 width ", rq}, int'(act_width), w);
    chk(int'(act_height) == h, {"R3 height ", rq}, int'(act_height), h);
  endtask

  task automatic run_change(input bit mode_vs);
    run_cfg(mode_vs, 4, 3);
    seen_low = 0;
    frame(5, 2, mode_vs);
    // R7: old dimensions held after the first differing frame
    chk(int'(act_width) == 4, "R7 hold width", int'(act_width), 4);
    chk(int'(act_height) == 3, "R7 hold height", int'(act_height), 3);
    frame(5, 2, mode_vs);
    frame(5, 2, mode_vs);
    chk(seen_low, "R7 valid dropped", int'(seen_low), 1);
    chk(dims_valid && int'(act_width) == 5, "R7 new width", int'(act_width), 5);
    chk(int'(act_height) == 2, "R7 new height", int'(act_height), 2);
  endtask

  initial begin
    for (int m = 0; m < 2; m++)
      for (int wi = 0; wi < 4; wi++)
        for (int h = 1; h <= 5; h += 2)
          run_cfg(m[0], (wi == 3) ? 7 : wi + 1, h);
    run_change(1'b0);
    run_change(1'b1);
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(200000 * 20);
    if (!done) begin
      bad++;
      $display("FAIL R1 watchdog actual=%0d expected=%0d", 0, 1);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule